// File: doc/BRIEF.md
# Configuration Shadow Mismatch Reset Monitor

This block keeps the configuration words of a chip in two register banks: a primary bank that feeds the rest of the design and a guard bank that holds the bitwise inverse of every primary word. In normal operation the two banks are compared on every clock cycle. If any bit pair stops being complementary, for example after a disturbance corrupts a flip-flop, the block raises a one-cycle mismatch pulse. The pulse starts the same restart path an external master-clear request would start.

Every restart refills both banks from a non-volatile source. A power-on reset, an external reset request or a detected mismatch can each cause a restart. The refill walks the word index from 0 upward, reads one word per cycle through a plain index/data port, and writes the word to the primary bank and its inverse to the guard bank. The system reset output stays high for the whole refill. Comparison is disarmed until the last word has been written.

An 8-bit status register records the cause. Bit 5 drops to 0 when a mismatch reset happens, and no other reset cause touches it. Only a power-on reset or a software write sets it back to 1. A test port flips any single bit in either bank so that the detector can be exercised.

Top module: `cfg_shadow_monitor`

## Requirements
- R1: While `rst` is high, `sys_rst_o` reads 1. After the last edge that requested a reload, it falls at the N_WORDS-th rising edge.
- R2: When a reload completes, word i of `cfg_o` (bits i*WORD_W upward) equals the value the source presented on `nv_data_i` while `nv_idx_o` was i.
- R3: While both banks hold complementary contents, `mm_rst_o` stays 0.
- R4: A bit flipped through the test port while armed, in either bank (`inj_shadow_i` 0 selects the primary bank, 1 the guard bank), raises `mm_rst_o` at the next rising edge for exactly one cycle.
- R5: One edge after `mm_rst_o` is high, `sys_rst_o` rises and a full reload runs, after which the banks are consistent again.
- R6: One edge after `mm_rst_o` is high, bit 5 of `stat_o` reads 0.
- R7: A power-on reset (`rst`) sets `stat_o` to 8'h20: bit 5 is 1 and all other bits are 0. All bits other than bit 5 always read 0.
- R8: `ext_rst_i` starts a reload that is held while it stays high. It leaves bit 5 of `stat_o` unchanged, whether that bit is 0 or 1.
- R9: A write (`stat_we_i`) loads bit 5 from `stat_wbit_i` at the next edge. A mismatch pulse in the same cycle wins, and the bit goes to 0.
- R10: During a reload the comparison is disarmed. A fault injected into a word that the reload has not yet written produces no `mm_rst_o` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| ext_rst_i | input | 1 | External master-clear style reset request |
| nv_idx_o | output | IDX_W | Word index presented to the non-volatile source |
| nv_data_i | input | WORD_W | Word returned by the source for `nv_idx_o` (same cycle) |
| inj_en_i | input | 1 | Test-port fault strobe |
| inj_shadow_i | input | 1 | 0 selects the primary bank, 1 the guard bank |
| inj_idx_i | input | IDX_W | Word to corrupt |
| inj_bit_i | input | BIT_W | Bit to flip |
| stat_we_i | input | 1 | Software write strobe for the status flag |
| stat_wbit_i | input | 1 | Value written to status bit 5 |
| cfg_o | output | N_WORDS*WORD_W | Primary configuration words, word 0 in the low bits |
| mm_rst_o | output | 1 | One-cycle mismatch reset pulse |
| sys_rst_o | output | 1 | System reset, high during every reload |
| stat_o | output | 8 | Reset status; bit 5 is 0 after a mismatch reset |

## Verification
The bench flips every bit of every word in both banks one at a time. After each flip it checks the following:
- The pulse lands on exactly the next edge and lasts one cycle. A detector with an extra register or no re-arm guard would show a late or stretched pulse.
- The status bit falls on the cycle after the pulse.
- The reload that follows fetches fresh source contents. A monitor that skipped the refill would leave stale words on `cfg_o`.

Several collision cases are also covered:
- External resets arrive with the flag at 0 and at 1. A design that lumps every reset cause together would alter the flag.
- A software set is issued in the same cycle as a mismatch. Wrong priority would leave the flag at 1.
- A fault is injected into a word that has not yet been reloaded. A detector armed too early would fire during the refill.

// File: rtl/cfgmon_pkg.sv
package cfgmon_pkg;

  localparam int STAT_W      = 8;
  localparam int STAT_MM_BIT = 5;

  typedef enum logic [0:0] {
    SEQ_LOAD = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;

endpackage

// File: rtl/cfgmon_bank.sv
// One bank of configuration words: reload write port plus single-bit fault flip.
module cfgmon_bank #(
  parameter int N_WORDS = 4,
  parameter int WORD_W  = 8,
  parameter bit INVERT  = 1'b0,
  localparam int IDX_W  = (N_WORDS > 1) ? $clog2(N_WORDS) : 1,
  localparam int BIT_W  = (WORD_W > 1) ? $clog2(WORD_W) : 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        ld_en,
  input  logic [IDX_W-1:0]            ld_idx,
  input  logic [WORD_W-1:0]           ld_data,
  input  logic                        inj_en,
  input  logic [IDX_W-1:0]            inj_idx,
  input  logic [BIT_W-1:0]            inj_bit,
  output logic [N_WORDS*WORD_W-1:0]   words_o
);

  localparam logic [WORD_W-1:0] RST_WORD = INVERT ? {WORD_W{1'b1}} : {WORD_W{1'b0}};

  logic [WORD_W-1:0] store_val;
  logic [WORD_W-1:0] flip_mask;

  // The guard bank stores the complement of the fetched word.
  assign store_val = INVERT ? ~ld_data : ld_data;
  assign flip_mask = WORD_W'(1) << inj_bit;

  for (genvar g = 0; g < N_WORDS; g++) begin : g_word
    logic [WORD_W-1:0] word_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        word_q <= RST_WORD;
      end else if (ld_en && (ld_idx == IDX_W'(g))) begin
        word_q <= store_val;
      end else if (inj_en && (inj_idx == IDX_W'(g))) begin
        word_q <= word_q ^ flip_mask;
      end
    end

    assign words_o[g*WORD_W +: WORD_W] = word_q;
  end

endmodule

// File: rtl/cfgmon_cmp.sv
// Parallel complement check across all word pairs, registered pulse out.
module cfgmon_cmp #(
  parameter int N_WORDS = 4,
  parameter int WORD_W  = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        arm,
  input  logic [N_WORDS*WORD_W-1:0]   pri_words,
  input  logic [N_WORDS*WORD_W-1:0]   grd_words,
  output logic                        mm_q
);

  logic [N_WORDS-1:0] word_bad;

  for (genvar g = 0; g < N_WORDS; g++) begin : g_pair
    logic [WORD_W-1:0] pair_x;
    assign pair_x      = pri_words[g*WORD_W +: WORD_W] ^ grd_words[g*WORD_W +: WORD_W];
    assign word_bad[g] = (pair_x != {WORD_W{1'b1}});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mm_q <= 1'b0;
    end else begin
      mm_q <= arm & (|word_bad);
    end
  end

endmodule

// File: rtl/cfgmon_seq.sv
// Reload sequencer: walks word indices, holds system reset, arms the compare.
module cfgmon_seq
  import cfgmon_pkg::*;
#(
  parameter int N_WORDS = 4,
  localparam int IDX_W  = (N_WORDS > 1) ? $clog2(N_WORDS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ext_rst_i,
  input  logic             mm_i,
  output logic             ld_en,
  output logic [IDX_W-1:0] ld_idx,
  output logic             arm,
  output logic             sys_rst_o
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_WORDS - 1);

  seq_state_e       state_q, state_n;
  logic [IDX_W-1:0] idx_q, idx_n;
  logic             sys_rst_q;

  always_comb begin
    state_n = state_q;
    idx_n   = idx_q;
    if (ext_rst_i || (state_q == SEQ_RUN && mm_i)) begin
      state_n = SEQ_LOAD;
      idx_n   = '0;
    end else if (state_q == SEQ_LOAD) begin
      if (idx_q == LAST_IDX) begin
        state_n = SEQ_RUN;
        idx_n   = '0;
      end else begin
        idx_n = idx_q + IDX_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= SEQ_LOAD;
      idx_q     <= '0;
      sys_rst_q <= 1'b1;
    end else begin
      state_q   <= state_n;
      idx_q     <= idx_n;
      sys_rst_q <= (state_n == SEQ_LOAD);
    end
  end

  assign ld_en     = (state_q == SEQ_LOAD);
  assign ld_idx    = idx_q;
  // Re-arm only once every pair is written; hold off while a pulse or request is in flight.
  assign arm       = (state_q == SEQ_RUN) && !mm_i && !ext_rst_i;
  assign sys_rst_o = sys_rst_q;

endmodule

// File: rtl/cfgmon_stat.sv
// Sticky reset-cause register; only the mismatch flag is implemented.
module cfgmon_stat
  import cfgmon_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              mm_i,
  input  logic              we_i,
  input  logic              wbit_i,
  output logic [STAT_W-1:0] stat_o
);

  logic flag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b1;
    end else if (mm_i) begin
      flag_q <= 1'b0;
    end else if (we_i) begin
      flag_q <= wbit_i;
    end
  end

  always_comb begin
    stat_o              = '0;
    stat_o[STAT_MM_BIT] = flag_q;
  end

endmodule

// File: rtl/cfg_shadow_monitor.sv
module cfg_shadow_monitor
  import cfgmon_pkg::*;
#(
  parameter int N_WORDS = 4,
  parameter int WORD_W  = 8,
  localparam int IDX_W  = (N_WORDS > 1) ? $clog2(N_WORDS) : 1,
  localparam int BIT_W  = (WORD_W > 1) ? $clog2(WORD_W) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      ext_rst_i,
  output logic [IDX_W-1:0]          nv_idx_o,
  input  logic [WORD_W-1:0]         nv_data_i,
  input  logic                      inj_en_i,
  input  logic                      inj_shadow_i,
  input  logic [IDX_W-1:0]          inj_idx_i,
  input  logic [BIT_W-1:0]          inj_bit_i,
  input  logic                      stat_we_i,
  input  logic                      stat_wbit_i,
  output logic [N_WORDS*WORD_W-1:0] cfg_o,
  output logic                      mm_rst_o,
  output logic                      sys_rst_o,
  output logic [STAT_W-1:0]         stat_o
);

  logic                      ld_en;
  logic [IDX_W-1:0]          ld_idx;
  logic                      arm;
  logic                      mm_q;
  logic [N_WORDS*WORD_W-1:0] pri_words;
  logic [N_WORDS*WORD_W-1:0] grd_words;

  cfgmon_seq #(.N_WORDS(N_WORDS)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .ext_rst_i (ext_rst_i),
    .mm_i      (mm_q),
    .ld_en     (ld_en),
    .ld_idx    (ld_idx),
    .arm       (arm),
    .sys_rst_o (sys_rst_o)
  );

  cfgmon_bank #(.N_WORDS(N_WORDS), .WORD_W(WORD_W), .INVERT(1'b0)) u_pri (
    .clk     (clk),
    .rst     (rst),
    .ld_en   (ld_en),
    .ld_idx  (ld_idx),
    .ld_data (nv_data_i),
    .inj_en  (inj_en_i & ~inj_shadow_i),
    .inj_idx (inj_idx_i),
    .inj_bit (inj_bit_i),
    .words_o (pri_words)
  );

  cfgmon_bank #(.N_WORDS(N_WORDS), .WORD_W(WORD_W), .INVERT(1'b1)) u_grd (
    .clk     (clk),
    .rst     (rst),
    .ld_en   (ld_en),
    .ld_idx  (ld_idx),
    .ld_data (nv_data_i),
    .inj_en  (inj_en_i & inj_shadow_i),
    .inj_idx (inj_idx_i),
    .inj_bit (inj_bit_i),
    .words_o (grd_words)
  );

  cfgmon_cmp #(.N_WORDS(N_WORDS), .WORD_W(WORD_W)) u_cmp (
    .clk       (clk),
    .rst       (rst),
    .arm       (arm),
    .pri_words (pri_words),
    .grd_words (grd_words),
    .mm_q      (mm_q)
  );

  cfgmon_stat u_stat (
    .clk    (clk),
    .rst    (rst),
    .mm_i   (mm_q),
    .we_i   (stat_we_i),
    .wbit_i (stat_wbit_i),
    .stat_o (stat_o)
  );

  assign nv_idx_o = ld_idx;
  assign cfg_o    = pri_words;
  assign mm_rst_o = mm_q;

endmodule

// File: rtl/cfg_shadow_monitor_chk.sv
module cfg_shadow_monitor_chk (
  input logic       clk,
  input logic       rst,
  input logic       ext_rst_i,
  input logic       stat_we_i,
  input logic       stat_wbit_i,
  input logic       mm_rst_o,
  input logic       sys_rst_o,
  input logic [7:0] stat_o
);

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    mm_rst_o |=> !mm_rst_o); // R4

  AST_MM_STARTS_RELOAD: assert property (@(posedge clk) disable iff (rst)
    mm_rst_o |=> sys_rst_o); // R5

  AST_MM_CLEARS_FLAG: assert property (@(posedge clk) disable iff (rst)
    mm_rst_o |=> !stat_o[5]); // R6

  AST_EXT_KEEPS_FLAG: assert property (@(posedge clk) disable iff (rst)
    (ext_rst_i && !stat_we_i && !mm_rst_o) |=> $stable(stat_o[5])); // R8

  AST_FLAG_SET_SRC: assert property (@(posedge clk) disable iff (rst)
    $rose(stat_o[5]) |-> ($past(stat_we_i) && $past(stat_wbit_i))); // R9

  AST_NO_MM_IN_RELOAD: assert property (@(posedge clk) disable iff (rst)
    sys_rst_o |-> !mm_rst_o); // R10

endmodule

bind cfg_shadow_monitor cfg_shadow_monitor_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .ext_rst_i   (ext_rst_i),
  .stat_we_i   (stat_we_i),
  .stat_wbit_i (stat_wbit_i),
  .mm_rst_o    (mm_rst_o),
  .sys_rst_o   (sys_rst_o),
  .stat_o      (stat_o)
);

// File: tb/cfg_shadow_monitor_tb.sv
module cfg_shadow_monitor_tb;

  localparam int N  = 4;
  localparam int W  = 8;
  localparam int IW = 2;
  localparam int BW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ext_rst_i = 1'b0;
  logic [IW-1:0] nv_idx_o;
  logic [W-1:0]  nv_data_i;
  logic          inj_en_i = 1'b0;
  logic          inj_shadow_i = 1'b0;
  logic [IW-1:0] inj_idx_i = '0;
  logic [BW-1:0] inj_bit_i = '0;
  logic          stat_we_i = 1'b0;
  logic          stat_wbit_i = 1'b0;
  logic [N*W-1:0] cfg_o;
  logic          mm_rst_o;
  logic          sys_rst_o;
  logic [7:0]    stat_o;

  int n_chk  = 0;
  int n_fail = 0;
  int epoch  = 0;

  always #2.5 clk = ~clk;

  function automatic logic [W-1:0] nv_val(int i, int e);
    return W'(((i * 29) + 7) ^ (e * 53));
  endfunction

  function automatic logic [N*W-1:0] exp_cfg(int e);
    logic [N*W-1:0] v;
    for (int i = 0; i < N; i++) v[i*W +: W] = nv_val(i, e);
    return v;
  endfunction

  assign nv_data_i = nv_val(int'(nv_idx_o), epoch);

  cfg_shadow_monitor #(.N_WORDS(N), .WORD_W(W)) u_dut (
    .clk          (clk),
    .rst          (rst),
    .ext_rst_i    (ext_rst_i),
    .nv_idx_o     (nv_idx_o),
    .nv_data_i    (nv_data_i),
    .inj_en_i     (inj_en_i),
    .inj_shadow_i (inj_shadow_i),
    .inj_idx_i    (inj_idx_i),
    .inj_bit_i    (inj_bit_i),
    .stat_we_i    (stat_we_i),
    .stat_wbit_i  (stat_wbit_i),
    .cfg_o        (cfg_o),
    .mm_rst_o     (mm_rst_o),
    .sys_rst_o    (sys_rst_o),
    .stat_o       (stat_o)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // Called after the edge that put the sequencer in reload (already sampled).
  task automatic reload_tail(int first, logic [7:0] stat_exp);
    for (int j = first; j < N; j++) begin
      step();
      chk("R1 sys_rst held during reload", 64'(sys_rst_o), 64'd1);
      chk("R10 no pulse during reload", 64'(mm_rst_o), 64'd0);
    end
    step();
    chk("R1 sys_rst falls after N edges", 64'(sys_rst_o), 64'd0);
    chk("R2 cfg_o reloaded", 64'(cfg_o), 64'(exp_cfg(epoch)));
    chk("R8 status after reload", 64'(stat_o), 64'(stat_exp));
  endtask

  task automatic sw_write(logic b);
    stat_we_i   = 1'b1;
    stat_wbit_i = b;
    step();
    stat_we_i   = 1'b0;
    chk("R9 software write of flag", 64'(stat_o), b ? 64'h20 : 64'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired (all requirements)");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    // Power-on reset
    repeat (3) step();
    chk("R1 sys_rst during rst", 64'(sys_rst_o), 64'd1);
    chk("R7 reset status value", 64'(stat_o), 64'h20);
    chk("R3 no pulse in reset", 64'(mm_rst_o), 64'd0);
    rst = 1'b0;
    reload_tail(1, 8'h20);

    // Quiet running: banks consistent, no pulse
    for (int c = 0; c < 6; c++) begin
      step();
      chk("R3 quiet run", 64'(mm_rst_o), 64'd0);
    end

    // Exhaustive single-bit fault sweep over both banks
    for (int bank = 0; bank < 2; bank++) begin
      for (int w = 0; w < N; w++) begin
        for (int b = 0; b < W; b++) begin
          epoch++;
          inj_en_i     = 1'b1;
          inj_shadow_i = bank[0];
          inj_idx_i    = IW'(w);
          inj_bit_i    = BW'(b);
          step();
          inj_en_i = 1'b0;
          chk("R4 pulse not early", 64'(mm_rst_o), 64'd0);
          step();
          chk("R4 pulse on next edge", 64'(mm_rst_o), 64'd1);
          chk("R6 flag not yet cleared", 64'(stat_o), 64'h20);
          step();
          chk("R4 pulse is one cycle", 64'(mm_rst_o), 64'd0);
          chk("R5 reload started", 64'(sys_rst_o), 64'd1);
          chk("R6 flag cleared", 64'(stat_o), 64'h00);
          reload_tail(1, 8'h00);
          step();
          chk("R3 quiet after recovery", 64'(mm_rst_o), 64'd0);
          sw_write(1'b1);
        end
      end
    end

    // R7/R9: write clears and sets the flag, other bits remain 0
    sw_write(1'b0);
    sw_write(1'b1);

    // R8: external reset with flag = 1, held 3 edges
    epoch++;
    ext_rst_i = 1'b1;
    for (int c = 0; c < 3; c++) begin
      step();
      chk("R8 ext reset holds sys_rst", 64'(sys_rst_o), 64'd1);
    end
    ext_rst_i = 1'b0;
    reload_tail(1, 8'h20);

    // R8: external reset with flag = 0
    sw_write(1'b0);
    epoch++;
    ext_rst_i = 1'b1;
    step();
    ext_rst_i = 1'b0;
    chk("R8 ext reset keeps flag 0", 64'(stat_o), 64'h00);
    reload_tail(1, 8'h00);
    sw_write(1'b1);

    // R9: write of 1 in the same cycle as a mismatch pulse loses
    epoch++;
    inj_en_i = 1'b1; inj_shadow_i = 1'b0; inj_idx_i = IW'(1); inj_bit_i = BW'(2);
    step();
    inj_en_i = 1'b0;
    step();
    chk("R4 pulse for collision case", 64'(mm_rst_o), 64'd1);
    stat_we_i = 1'b1; stat_wbit_i = 1'b1;
    step();
    stat_we_i = 1'b0;
    chk("R9 mismatch wins over write", 64'(stat_o), 64'h00);
    reload_tail(1, 8'h00);
    sw_write(1'b1);

    // R10: fault into a word not yet reloaded produces no pulse
    epoch++;
    ext_rst_i = 1'b1;
    step();
    ext_rst_i = 1'b0;
    inj_en_i = 1'b1; inj_shadow_i = 1'b1; inj_idx_i = IW'(N - 1); inj_bit_i = BW'(0);
    step();
    inj_en_i = 1'b0;
    chk("R10 no pulse after early fault", 64'(mm_rst_o), 64'd0);
    reload_tail(2, 8'h20);
    for (int c = 0; c < 4; c++) begin
      step();
      chk("R10 fault overwritten, still quiet", 64'(mm_rst_o), 64'd0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule